// File: doc/BRIEF.md
# Multi-Rail Power-Good Supervisor Logic

This block is the digital decision core of a four-channel supply supervisor. Each rail has an analog comparator outside the block, and that comparator reports one bit meaning "rail above its trip point". The block synchronizes these bits. It filters out short dropouts and requires each rail to stay continuously compliant for a programmable stability time before it raises that rail's status flag. A combined power-good flag goes high only when every rail is compliant and monitoring is enabled.

Each channel keeps its own stability timer and its own dropout filter. A fault on one rail clears only that rail's flag. The combined flag falls with it, and it comes back only after the faulty rail has been revalidated. Dropping the enable input pulls the combined flag low at once, while the per-rail flags follow after a programmable hold time. A bias-ready input forces all outputs low while the supply sits below its lockout level.

In window mode, each rail also has an overvoltage comparator, and the rail counts as compliant only while it is above the undervoltage trip and below the overvoltage trip. An unused channel is tied to the compliant level so that it never holds the combined flag low. All timing parameters are counted in cycles of one free-running clock.

Top module: `rail_supervisor`

## Requirements
- R1: While `rst` is high, every `status` bit and `pgood` are 0. Reset and a low `bias_ok` both clear every timer.
- R2: Inputs `uv_ok`, `ov_hi` and `enable` pass through a two-flop synchronizer. A channel's `status` bit rises only after STAB_CYC consecutive compliant synchronized samples. If a compliant level is driven between clock edges, the bit is 1 after the (2+STAB_CYC)-th following rising edge and still 0 after the one before.
- R3: While a channel's `status` bit is 0, a single non-compliant sample restarts that channel's stability count from zero.
- R4: While a channel's `status` bit is 1, a run of fewer than FILT_CYC consecutive non-compliant samples has no effect on any output.
- R5: A run of FILT_CYC consecutive non-compliant samples clears that channel's `status` bit after the (2+FILT_CYC)-th edge after the input change. Every other channel's bit is unchanged.
- R6: `pgood` equals the AND of all four `status` bits, the raw `enable` input and the raw `bias_ok` input. It is combinational in the last two.
- R7: When `enable` falls, `pgood` falls with no clock edge needed. The `status` bits stay 1 through the (2+EN_OFF_CYC)-th edge and are 0 after the (3+EN_OFF_CYC)-th edge.
- R8: When `enable` rises while all rails are compliant, the status bits and `pgood` rise after the (2+STAB_CYC)-th edge and not before.
- R9: While `bias_ok` is 0, `status` and `pgood` are 0 with no clock edge needed. After `bias_ok` returns to 1 with rails compliant, the status bits rise after the STAB_CYC-th edge and not before.
- R10: With WINDOW=1, a channel is compliant only when `uv_ok`=1 and `ov_hi`=0. With WINDOW=0, `ov_hi` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous reset, active high |
| bias_ok | input | 1 | Supply above lockout level, active high |
| enable | input | 1 | Monitoring enable, active high (asynchronous) |
| uv_ok | input | NUM_CH | Per rail: above undervoltage trip (asynchronous) |
| ov_hi | input | NUM_CH | Per rail: above overvoltage trip, used in window mode (asynchronous) |
| status | output | NUM_CH | Per-rail compliance flag |
| pgood | output | 1 | All rails compliant and monitoring enabled |

## Verification
The bench sweeps every channel with every dropout length below the filter limit, then with the length that exactly meets it. A filter that is off by one either drops a flag on a tolerated glitch or keeps it through a real fault. It also checks that the other three flags stay up, which catches a design that clears all channels on a single fault. It samples one edge before and one edge on each expected transition for rail recovery, enable-on, enable-off and bias return, so a stability or hold timer that is one cycle short or long is reported. A one-cycle glitch during revalidation exposes a timer that pauses instead of restarting. A second instance in window mode, fed the same stimulus, shows that the overvoltage input is honoured there and ignored in rail mode.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic {
    CH_QUALIFY = 1'b0,
    CH_GOOD    = 1'b1
  } ch_state_t;

  // Width of a counter that must hold values 0..max_val.
  function automatic int cnt_width(input int max_val);
    return (max_val < 1) ? 1 : $clog2(max_val + 1);
  endfunction

  // A rail is compliant when above its low trip and, in window mode,
  // not above its high trip.
  function automatic logic rail_valid(input logic above_uv, input logic above_ov,
                                      input logic window);
    return above_uv & ~(window & above_ov);
  endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int WIDTH  = 9,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/supv_off_timer.sv
module supv_off_timer
  import supv_pkg::*;
#(
  parameter int HOLD_CYC = 325
) (
  input  logic clk,
  input  logic rst,
  input  logic en_s,
  output logic hold
);

  localparam int CW = cnt_width(HOLD_CYC);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

  logic [CW-1:0] off_cnt;

  // Counts synchronized-low enable samples, saturating at the limit.
  always_ff @(posedge clk) begin
    if (rst || en_s)         off_cnt <= '0;
    else if (off_cnt != LIMIT) off_cnt <= off_cnt + 1'b1;
  end

  // Released as soon as the synchronized enable is seen high again.
  assign hold = ~en_s & (off_cnt == LIMIT);

endmodule

// File: rtl/supv_channel.sv
module supv_channel
  import supv_pkg::*;
#(
  parameter int FILT_CYC = 750,
  parameter int STAB_CYC = 4000000
) (
  input  logic clk,
  input  logic rst,
  input  logic kill,
  input  logic vld,
  output logic ok
);

  localparam int SW = cnt_width(STAB_CYC);
  localparam int FW = cnt_width(FILT_CYC);
  localparam logic [SW-1:0] STAB_LAST = SW'(STAB_CYC - 1);
  localparam logic [FW-1:0] FILT_LAST = FW'(FILT_CYC - 1);

  ch_state_t state_q;
  logic [SW-1:0] stab_cnt;
  logic [FW-1:0] bad_cnt;

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      state_q  <= CH_QUALIFY;
      stab_cnt <= '0;
      bad_cnt  <= '0;
    end else begin
      unique case (state_q)
        CH_QUALIFY: begin
          bad_cnt <= '0;
          if (!vld) begin
            stab_cnt <= '0;
          end else if (stab_cnt == STAB_LAST) begin
            stab_cnt <= '0;
            state_q  <= CH_GOOD;
          end else begin
            stab_cnt <= stab_cnt + 1'b1;
          end
        end
        CH_GOOD: begin
          stab_cnt <= '0;
          if (vld) begin
            bad_cnt <= '0;
          end else if (bad_cnt == FILT_LAST) begin
            bad_cnt <= '0;
            state_q <= CH_QUALIFY;
          end else begin
            bad_cnt <= bad_cnt + 1'b1;
          end
        end
        default: state_q <= CH_QUALIFY;
      endcase
    end
  end

  assign ok = (state_q == CH_GOOD);

endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor
  import supv_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 750,
  parameter int STAB_CYC    = 4000000,
  parameter int EN_OFF_CYC  = 325,
  parameter bit WINDOW      = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bias_ok,
  input  logic              enable,
  input  logic [NUM_CH-1:0] uv_ok,
  input  logic [NUM_CH-1:0] ov_hi,
  output logic [NUM_CH-1:0] status,
  output logic              pgood
);

  localparam int SYW = 2 * NUM_CH + 1;

  logic [SYW-1:0]    sync_d, sync_q;
  logic [NUM_CH-1:0] uv_s, ov_s, vld_s, status_q;
  logic              en_s, hold, kill;

  assign sync_d = {enable, ov_hi, uv_ok};

  supv_sync #(
    .WIDTH (SYW),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (sync_d),
    .q  (sync_q)
  );

  assign uv_s = sync_q[NUM_CH-1:0];
  assign ov_s = sync_q[2*NUM_CH-1:NUM_CH];
  assign en_s = sync_q[SYW-1];

  supv_off_timer #(
    .HOLD_CYC(EN_OFF_CYC)
  ) u_off (
    .clk (clk),
    .rst (rst),
    .en_s(en_s),
    .hold(hold)
  );

  // Lockout acts on the raw bias input so it does not wait for a clock.
  assign kill = ~bias_ok | hold;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign vld_s[g] = rail_valid(uv_s[g], ov_s[g], WINDOW);

    supv_channel #(
      .FILT_CYC(FILT_CYC),
      .STAB_CYC(STAB_CYC)
    ) u_ch (
      .clk (clk),
      .rst (rst),
      .kill(kill),
      .vld (vld_s[g]),
      .ok  (status_q[g])
    );
  end

  assign status = status_q & {NUM_CH{bias_ok}};
  assign pgood  = (&status_q) & enable & bias_ok;

endmodule

// File: rtl/supv_checker.sv
module supv_checker #(
  parameter int N    = 4,
  parameter int FILT = 750,
  parameter int STAB = 4000000
) (
  input logic         clk,
  input logic         rst,
  input logic         bias_ok,
  input logic         enable,
  input logic         pgood,
  input logic [N-1:0] status,
  input logic [N-1:0] status_q,
  input logic [N-1:0] vld_s,
  input logic         kill,
  input logic         hold
);

  localparam int VW = $clog2(STAB + 2);
  localparam int IW = $clog2(FILT + 2);

  // R6
  pgood_all_chk: assert property (@(posedge clk) disable iff (rst)
    pgood |-> ((&status) && enable));

  // R9
  lockout_chk: assert property (@(posedge clk) disable iff (rst)
    !bias_ok |-> (status == '0 && !pgood));

  // R7
  hold_clear_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (status_q == '0));

  for (genvar g = 0; g < N; g++) begin : g_mon
    logic [VW-1:0] good_run;
    logic [IW-1:0] bad_run;

    always_ff @(posedge clk) begin
      if (rst || !vld_s[g])            good_run <= '0;
      else if (good_run != VW'(STAB))  good_run <= good_run + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst || vld_s[g])             bad_run <= '0;
      else if (bad_run != IW'(FILT))   bad_run <= bad_run + 1'b1;
    end

    // R2
    stab_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(status_q[g]) |-> (good_run >= VW'(STAB)));

    // R5
    filt_fall_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(status_q[g]) |-> ((bad_run >= IW'(FILT)) || $past(kill)));
  end

endmodule

bind rail_supervisor supv_checker #(
  .N   (NUM_CH),
  .FILT(FILT_CYC),
  .STAB(STAB_CYC)
) u_supv_chk (
  .clk     (clk),
  .rst     (rst),
  .bias_ok (bias_ok),
  .enable  (enable),
  .pgood   (pgood),
  .status  (status),
  .status_q(status_q),
  .vld_s   (vld_s),
  .kill    (kill),
  .hold    (hold)
);

// File: tb/rail_supervisor_test.sv
module rail_supervisor_test;

  localparam int FILT = 4;
  localparam int STAB = 20;
  localparam int OFF  = 6;

  logic       clk = 1'b0;
  logic       rst, bias_ok, enable;
  logic [3:0] uv_ok, ov_hi;
  logic [3:0] status, status_w;
  logic       pgood, pgood_w;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  rail_supervisor #(.NUM_CH(4), .SYNC_STAGES(2), .FILT_CYC(FILT), .STAB_CYC(STAB),
                    .EN_OFF_CYC(OFF), .WINDOW(1'b0)) uut (
    .clk(clk), .rst(rst), .bias_ok(bias_ok), .enable(enable),
    .uv_ok(uv_ok), .ov_hi(ov_hi), .status(status), .pgood(pgood));

  rail_supervisor #(.NUM_CH(4), .SYNC_STAGES(2), .FILT_CYC(FILT), .STAB_CYC(STAB),
                    .EN_OFF_CYC(OFF), .WINDOW(1'b1)) uut_w (
    .clk(clk), .rst(rst), .bias_ok(bias_ok), .enable(enable),
    .uv_ok(uv_ok), .ov_hi(ov_hi), .status(status_w), .pgood(pgood_w));

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {pgood,status} got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst = 1'b1; bias_ok = 1'b1; enable = 1'b1; uv_ok = 4'hF; ov_hi = 4'h0;
    tick(3);
    chk("R1 reset", {pgood, status}, 5'h00);
    chk("R1 reset win", {pgood_w, status_w}, 5'h00);

    // Bring-up: first compliant sync sample at edge 3
    @(negedge clk) rst = 1'b0;
    tick(1 + STAB);
    chk("R2 before stab", {pgood, status}, 5'h00);
    tick(1);
    chk("R2 after stab", {pgood, status}, 5'h1F);
    chk("R6 all good", {pgood_w, status_w}, 5'h1F);

    // R4: every channel, every tolerated dropout length
    for (int ch = 0; ch < 4; ch++) begin
      for (int len = 1; len < FILT; len++) begin
        @(negedge clk) uv_ok[ch] = 1'b0;
        repeat (len) @(posedge clk);
        @(negedge clk) uv_ok[ch] = 1'b1;
        for (int k = 0; k < 6; k++) begin
          tick(1);
          chk("R4 glitch ignored", {pgood, status}, 5'h1F);
        end
      end
    end

    // R5: fault of exactly FILT samples on each channel, then recovery
    for (int ch = 0; ch < 4; ch++) begin
      @(negedge clk) uv_ok[ch] = 1'b0;
      tick(1 + FILT);
      chk("R4 edge of filter", {pgood, status}, 5'h1F);
      tick(1);
      chk("R5 channel dropped", {pgood, status}, {1'b0, 4'hF & ~(4'h1 << ch)});
      chk("R5 channel dropped win", {pgood_w, status_w}, {1'b0, 4'hF & ~(4'h1 << ch)});
      @(negedge clk) uv_ok[ch] = 1'b1;
      tick(1 + STAB);
      chk("R2 recover before", {pgood, status}, {1'b0, 4'hF & ~(4'h1 << ch)});
      tick(1);
      chk("R2 recover after", {pgood, status}, 5'h1F);
    end

    // R3: glitch during revalidation restarts the count
    @(negedge clk) uv_ok[1] = 1'b0;
    tick(FILT + 3);
    chk("R5 ch1 down", {pgood, status}, 5'h0D);
    @(negedge clk) uv_ok[1] = 1'b1;
    tick(STAB / 2);
    @(negedge clk) uv_ok[1] = 1'b0;
    @(negedge clk) uv_ok[1] = 1'b1;
    tick(1 + STAB);
    chk("R3 restarted, still low", {pgood, status}, 5'h0D);
    tick(1);
    chk("R3 restarted, now high", {pgood, status}, 5'h1F);

    // R7: enable off
    @(negedge clk) enable = 1'b0;
    #1;
    chk("R7 pgood immediate", {pgood, status}, 5'h0F);
    chk("R7 pgood immediate win", {pgood_w, status_w}, 5'h0F);
    tick(2 + OFF);
    chk("R7 status held", {pgood, status}, 5'h0F);
    tick(1);
    chk("R7 status cleared", {pgood, status}, 5'h00);
    tick(5);
    chk("R7 stays cleared", {pgood, status}, 5'h00);

    // R8: enable on
    @(negedge clk) enable = 1'b1;
    tick(1 + STAB);
    chk("R8 before delay", {pgood, status}, 5'h00);
    tick(1);
    chk("R8 after delay", {pgood, status}, 5'h1F);

    // R9: bias lockout
    @(negedge clk) bias_ok = 1'b0;
    #1;
    chk("R9 lockout immediate", {pgood, status}, 5'h00);
    chk("R9 lockout immediate win", {pgood_w, status_w}, 5'h00);
    tick(3);
    chk("R9 lockout held", {pgood, status}, 5'h00);
    @(negedge clk) bias_ok = 1'b1;
    tick(STAB - 1);
    chk("R9 timers restarted", {pgood, status}, 5'h00);
    tick(1);
    chk("R9 back up", {pgood, status}, 5'h1F);

    // R10: overvoltage input
    @(negedge clk) ov_hi[2] = 1'b1;
    tick(1 + FILT);
    chk("R10 window before filter", {pgood_w, status_w}, 5'h1F);
    tick(1);
    chk("R10 window dropped", {pgood_w, status_w}, 5'h0B);
    chk("R10 rail mode ignores ov", {pgood, status}, 5'h1F);
    tick(3);
    chk("R10 rail mode still good", {pgood, status}, 5'h1F);
    @(negedge clk) ov_hi[2] = 1'b0;
    tick(1 + STAB);
    chk("R10 window before recover", {pgood_w, status_w}, 5'h0B);
    tick(1);
    chk("R10 window recovered", {pgood_w, status_w}, 5'h1F);

    finish_run();
  end

endmodule